// File: doc/BRIEF.md
# Dual-Section Latched Bus Transceiver

This block models a pair of 8-bit bus transceivers. Each section sits between an A port and a B port and holds one storage latch per direction. Each direction has three active-low controls: a path enable, a latch enable and an output enable. With both the path enable and the latch enable low, the path is transparent. A rising edge on either of those two captures the input data and then holds it. The far port drives the stored value only while the path enable and the output enable are both low.

Neither port uses tri-state pins. Each port has a data input, a data output and an active-high drive flag, and the surrounding logic resolves the shared wire from these. The model is synchronous. Every control and data input is sampled on the system clock, and control edges are found by comparing each input with its value from the previous clock. Each result appears on the outputs one clock after the edge that sampled its cause. Reset asserts asynchronously (active low) and is released through a two-stage synchronizer. The top holds two independent sections, and each section has its own six controls.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While reset is asserted, and after it is released, every drive flag is 0 and every data output is 0. A later output enable without a capture therefore shows 0.
- R2: When the path enable and the latch enable of a direction are both low at a clock edge, that direction's output equals the input data sampled at that edge, from the next cycle on.
- R3: When the latch enable is high at an edge but was low at the previous edge, the input data sampled at that edge is captured and shown from the next cycle.
- R4: When the path enable is high at an edge but was low at the previous edge, the input data sampled at that edge is captured and shown from the next cycle.
- R5: When a direction is neither transparent nor at a capture edge, its data output keeps its value, whatever the input data does.
- R6: When the path enable and the output enable of a direction are both low at an edge, that direction's drive flag is 1 in the next cycle.
- R7: When either the path enable or the output enable of a direction is high at an edge, that direction's drive flag is 0 in the next cycle, whatever the latch enable is.
- R8: The A-to-B and B-to-A directions of one section do not affect each other. A-to-B takes A data and outputs on the B side. B-to-A takes B data and outputs on the A side.
- R9: The two sections are independent. Section s uses bit s of each control vector, bit s of each drive flag, and data bits [8s+7:8s].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_en_n | input | 2 | A-to-B path enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_en_n | input | 2 | B-to-A path enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |
| a_in | input | 16 | Data seen on the A ports |
| b_in | input | 16 | Data seen on the B ports |
| a_out | output | 16 | Data the B-to-A latches present to the A ports |
| a_drv | output | 2 | A port drive flag per section, active high |
| b_out | output | 16 | Data the A-to-B latches present to the B ports |
| b_drv | output | 2 | B port drive flag per section, active high |

## Verification
Every data and drive result is due exactly one clock after the rising edge that samples its controls. The reset release is the exception: the first edge that acts on inputs is the third rising edge after rst_n goes high. The bench changes inputs at the falling edge and updates its expected state for the coming rising edge. It compares at the next falling edge, so each comparison falls half a period after the edge that made the result. An asynchronous reset assertion is checked one nanosecond after it, with no clock edge between.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_dir_latch.sv
module xcvr_dir_latch
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctl_t         ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drv
);
  logic             en_q, le_q, drv_q;
  logic             pass_open, cap_edge, load, drv_d;
  logic [WIDTH-1:0] store_q;

  always_comb begin
    pass_open = !ctl.en_n && !ctl.le_n;
    cap_edge  = (ctl.en_n && !en_q) || (ctl.le_n && !le_q);
    load      = pass_open || cap_edge;
    drv_d     = !ctl.en_n && !ctl.oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      le_q  <= 1'b1;
      drv_q <= 1'b0;
    end else begin
      en_q  <= ctl.en_n;
      le_q  <= ctl.le_n;
      drv_q <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (load) begin
      store_q <= din;
    end
  end

  assign dout = store_q;
  assign drv  = drv_q;

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en_n && !ctl.le_n) |=> (dout == $past(din)));
  a_r3_le_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.le_n && !le_q) |=> (dout == $past(din)));
  a_r4_en_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en_n && !en_q) |=> (dout == $past(din)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.le_n && le_q && !(ctl.en_n && !en_q)) |=> $stable(dout));
  a_r6_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en_n && !ctl.oe_n) |=> drv);
  a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en_n || ctl.oe_n) |=> !drv);
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_en_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_en_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv
);
  dir_ctl_t ab_ctl, ba_ctl;

  always_comb begin
    ab_ctl = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
    ba_ctl = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
  end

  // R8: A data feeds the B side, B data feeds the A side
  xcvr_dir_latch #(.WIDTH(WIDTH)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl), .din(a_in), .dout(b_out), .drv(b_drv)
  );
  xcvr_dir_latch #(.WIDTH(WIDTH)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl), .din(b_in), .dout(a_out), .drv(a_drv)
  );

  a_r8_no_dual_drive_from_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_en_n && ba_en_n) |=> (!a_drv && !b_drv));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SECTIONS-1:0]       ab_en_n,
  input  logic [SECTIONS-1:0]       ab_le_n,
  input  logic [SECTIONS-1:0]       ab_oe_n,
  input  logic [SECTIONS-1:0]       ba_en_n,
  input  logic [SECTIONS-1:0]       ba_le_n,
  input  logic [SECTIONS-1:0]       ba_oe_n,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS-1:0]       a_drv,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS-1:0]       b_drv
);
  localparam int BUS_W = SECTIONS * WIDTH;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_LEN-1];

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    xcvr_section #(.WIDTH(WIDTH)) u_sec (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ab_en_n(ab_en_n[s]),
      .ab_le_n(ab_le_n[s]),
      .ab_oe_n(ab_oe_n[s]),
      .ba_en_n(ba_en_n[s]),
      .ba_le_n(ba_le_n[s]),
      .ba_oe_n(ba_oe_n[s]),
      .a_in   (a_in[s*WIDTH +: WIDTH]),
      .b_in   (b_in[s*WIDTH +: WIDTH]),
      .a_out  (a_out[s*WIDTH +: WIDTH]),
      .a_drv  (a_drv[s]),
      .b_out  (b_out[s*WIDTH +: WIDTH]),
      .b_drv  (b_drv[s])
    );
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (rst_core_n)
    1'b1 |-> (a_drv == '0 && b_drv == '0 && a_out == BUS_W'(0) && b_out == BUS_W'(0)));
endmodule

// File: tb/tb_dual_bus_xcvr.sv
`timescale 1ns/1ps
module tb_dual_bus_xcvr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
  logic [15:0] a_in, b_in, a_out, b_out;
  logic [1:0]  a_drv, b_drv;

  // path p: section p/2, direction p%2 (0 = A-to-B, 1 = B-to-A)
  // control code bit2 = en_n, bit1 = le_n, bit0 = oe_n
  logic [2:0] c_v [4];
  logic [7:0] d_v [4];
  logic [7:0] m_store [4];
  logic       m_drv [4];
  logic       m_enq [4];
  logic       m_leq [4];
  string      m_tag [4];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_bus_xcvr dut (
    .clk(clk), .rst_n(rst_n),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
    .b_out(b_out), .b_drv(b_drv)
  );

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      ab_en_n[s] = c_v[2*s][2];   ab_le_n[s] = c_v[2*s][1];   ab_oe_n[s] = c_v[2*s][0];
      ba_en_n[s] = c_v[2*s+1][2]; ba_le_n[s] = c_v[2*s+1][1]; ba_oe_n[s] = c_v[2*s+1][0];
      a_in[s*8 +: 8] = d_v[2*s];
      b_in[s*8 +: 8] = d_v[2*s+1];
    end
  end

  function automatic logic [7:0] get_out(int p);
    int s = p / 2;
    return (p % 2 == 0) ? b_out[s*8 +: 8] : a_out[s*8 +: 8];
  endfunction

  function automatic logic get_drv(int p);
    int s = p / 2;
    return (p % 2 == 0) ? b_drv[s] : a_drv[s];
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 4; p++) begin
      m_store[p] = 8'h00; m_drv[p] = 1'b0; m_enq[p] = 1'b1; m_leq[p] = 1'b1; m_tag[p] = "R1";
    end
  endtask

  task automatic check_path(int p, string dtag);
    string gtag;
    total += 2;
    if (get_out(p) !== m_store[p]) begin
      bad++;
      $display("FAIL %s path %0d data: actual=%h expected=%h", dtag, p, get_out(p), m_store[p]);
    end
    gtag = m_drv[p] ? "R6" : "R7";
    if (m_tag[p] == "R1") gtag = "R1";
    if (get_drv(p) !== m_drv[p]) begin
      bad++;
      $display("FAIL %s path %0d drive: actual=%b expected=%b", gtag, p, get_drv(p), m_drv[p]);
    end
  endtask

  task automatic check_all();
    for (int p = 0; p < 4; p++) check_path(p, m_tag[p]);
  endtask

  // model the edge that follows, then compare at the falling edge after it
  task automatic step();
    for (int p = 0; p < 4; p++) begin
      logic en, le, oe;
      en = c_v[p][2]; le = c_v[p][1]; oe = c_v[p][0];
      if (!en && !le)        begin m_store[p] = d_v[p]; m_tag[p] = "R2"; end
      else if (le && !m_leq[p]) begin m_store[p] = d_v[p]; m_tag[p] = "R3"; end
      else if (en && !m_enq[p]) begin m_store[p] = d_v[p]; m_tag[p] = "R4"; end
      else m_tag[p] = "R5";
      m_drv[p] = !en && !oe;
      m_enq[p] = en; m_leq[p] = le;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin c_v[p] = 3'b111; d_v[p] = 8'h00; end
    model_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all(); // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all(); // R1 after release
    // R1: enable output with no capture shows the cleared latch
    for (int p = 0; p < 4; p++) begin c_v[p] = 3'b010; d_v[p] = 8'hA5 + 8'(p); end
    step();
    for (int p = 0; p < 4; p++) check_path(p, "R1");

    // sweep every prev->cur control pair on every path, then a hold step with new data
    for (int j = 0; j < 64; j++) begin
      for (int ph = 0; ph < 3; ph++) begin
        for (int p = 0; p < 4; p++) begin
          if (ph == 0) c_v[p] = 3'(((j >> 3) + p) % 8);
          else if (ph == 1) c_v[p] = 3'(((j & 7) + 5 * p) % 8);
          d_v[p] = 8'((j * 37 + ph * 91 + p * 53 + 11) & 8'hFF);
        end
        step();
        check_all();
      end
    end

    // R8 and R9: all paths hold, then only path 0 runs transparent
    for (int p = 0; p < 4; p++) begin c_v[p] = 3'b010; d_v[p] = 8'h3C ^ 8'(p * 17); end
    step(); step();
    for (int k = 0; k < 6; k++) begin
      c_v[0] = 3'b000;
      for (int p = 0; p < 4; p++) d_v[p] = 8'(k * 29 + p * 7 + 1);
      step();
      check_path(0, "R2");
      check_path(1, "R8");
      check_path(2, "R9");
      check_path(3, "R9");
    end

    // R1: asynchronous reset assertion clears outputs without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    check_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule